// File: doc/BRIEF.md
# Configurable Trigger Interrupt Controller

This block gathers up to 32 interrupt sources and turns them into two request lines for a processor and a wake line for a power controller. Software chooses one trigger type per source: rising edge, falling edge, both edges, high level, low level, or off. Rising and falling edges are caught in two separate sticky latches, so software can acknowledge each direction on its own. Level triggers are never latched and follow the qualified input.

Every control field is changed through a pair of write-only alias addresses. Writing a one to a bit position in the set alias turns that bit on, and writing a one to the same position in the clear alias turns it off. Zero bits leave the field unchanged. A separate read-only address returns each field, so a driver can save the whole setup and later restore it by clearing everything and then setting the saved bits. Each source has a mask bit, a wake-enable bit, a routing bit that picks one of the two request lines, and a select bit. The select bit takes the source either from its pin, through a synchronizer, or from a word that software writes directly.

Top module: `tic_ctrl`

## Requirements
- R1: After reset the three trigger-config words, the mask, the wake word, both edge latches and the software source word are all zero. The routing word and the select word are all ones. All three outputs are low.
- R2: Control word k (k = 0 cfg0, 1 cfg1, 2 cfg2, 3 mask, 4 wake, 5 routing, 6 select) has its set alias at address 4k, its clear alias at 4k+1 and its read view at 4k+2. A write to the set alias ORs the data into the word. A write to the clear alias removes the one bits of the data from the word. Reading an address that is not mapped returns 0.
- R3: Trigger code {cfg2,cfg1,cfg0} = 001 latches a 0-to-1 transition of the qualified source. The source stays pending after the input returns low, and a 1-to-0 transition does not make it pending.
- R4: Code 010 latches a 1-to-0 transition and ignores a 0-to-1 transition.
- R5: Code 011 catches both directions. The rising latch (clear alias 29, read view 30) and the falling latch (clear alias 33, read view 34) are cleared independently. The source stays pending while either latch remains set.
- R6: Code 101 makes a source pending exactly while its qualified input is 1, and code 110 exactly while it is 0, with no latching.
- R7: Codes 000, 100 and 111 never make a source pending.
- R8: A source with its mask bit at 0 is absent from both pending words. Its edge latch still captures, so setting the mask later exposes the captured event.
- R9: A pending, unmasked source whose routing bit is 1 appears only in pending word 0 (read at address 36). With the routing bit at 0 it appears only in pending word 1 (read at address 37).
- R10: `irq0_o` is high exactly when pending word 0 is non-zero, and `irq1_o` is high exactly when pending word 1 is non-zero.
- R11: `wake_o` is high exactly when some source is active (pending before the mask) and has its wake bit set. The wake path does not depend on the mask.
- R12: With its select bit at 1, a source is taken from `src_i` through a two-flop synchronizer. A level-mode source therefore becomes pending after the second rising clock edge following the pin change, and the software source word (address 38) is ignored. With the select bit at 0, the corresponding bit of the software source word is used directly.
- R13: When an edge is detected in the same cycle that software clears that latch bit, the latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Raw interrupt source pins |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 6 | Write address |
| wr_data | input | N_SRC | Write data, one bit per source |
| rd_addr | input | 6 | Read address |
| rd_data | output | N_SRC | Read data, combinational from rd_addr |
| irq0_o | output | 1 | Request line 0 |
| irq1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wake request |

## Verification
The hardest case to reach from the ports is the collision in which a freshly detected edge and a software clear of the same latch bit land on the same clock edge. The detection pulse lasts exactly one cycle after the qualified input changes. The bench routes the source from the software word, so the input change happens on a known write edge, and it issues the latch clear on the very next write cycle. Edge and level behaviour is walked through a table of trigger codes and before/after input levels. The pin path is then timed cycle by cycle to pin down the synchronizer latency.

// File: rtl/tic_pkg.sv
package tic_pkg;
   localparam int ADDR_W   = 6;
   localparam int NREG     = 7;
   localparam int R_CFG0   = 0;
   localparam int R_CFG1   = 1;
   localparam int R_CFG2   = 2;
   localparam int R_MASK   = 3;
   localparam int R_WAKE   = 4;
   localparam int R_ROUTE  = 5;
   localparam int R_SELECT = 6;
   localparam int A_RISE_CLR = 29;
   localparam int A_RISE_RD  = 30;
   localparam int A_FALL_CLR = 33;
   localparam int A_FALL_RD  = 34;
   localparam int A_REQ0     = 36;
   localparam int A_REQ1     = 37;
   localparam int A_SWSRC    = 38;

   function automatic int a_set(input int k);
      return 4 * k;
   endfunction
   function automatic int a_clr(input int k);
      return 4 * k + 1;
   endfunction
   function automatic int a_rd(input int k);
      return 4 * k + 2;
   endfunction
endpackage

// File: rtl/tic_setclr_reg.sv
module tic_setclr_reg #(
   parameter int          W   = 32,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   // set takes precedence so an event arriving with a clear is kept
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= RST;
      else        q_o <= (q_o & ~clr_i) | set_i;
   end
endmodule

// File: rtl/tic_sync.sv
module tic_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tic_sync needs at least two stages");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tic_trigger.sv
module tic_trigger #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sel_i,
   input  logic [W-1:0] cfg0_i,
   input  logic [W-1:0] cfg1_i,
   input  logic [W-1:0] cfg2_i,
   input  logic [W-1:0] rise_clr_i,
   input  logic [W-1:0] fall_clr_i,
   output logic [W-1:0] rise_q_o,
   output logic [W-1:0] fall_q_o,
   output logic [W-1:0] active_o
);
   logic [W-1:0] prev_q;
   logic [W-1:0] rise_en, fall_en, hi_en, lo_en;
   logic [W-1:0] rose, fell;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sel_i;
   end

   // code {cfg2,cfg1,cfg0}: 001 rise, 010 fall, 011 both, 101 high, 110 low
   assign rise_en = ~cfg2_i & cfg0_i;
   assign fall_en = ~cfg2_i & cfg1_i;
   assign hi_en   =  cfg2_i & ~cfg1_i &  cfg0_i;
   assign lo_en   =  cfg2_i &  cfg1_i & ~cfg0_i;

   assign rose = sel_i & ~prev_q;
   assign fell = ~sel_i & prev_q;

   tic_setclr_reg #(.W(W), .RST('0)) u_rise (
      .clk(clk), .rst_n(rst_n),
      .set_i(rose & rise_en), .clr_i(rise_clr_i), .q_o(rise_q_o)
   );

   tic_setclr_reg #(.W(W), .RST('0)) u_fall (
      .clk(clk), .rst_n(rst_n),
      .set_i(fell & fall_en), .clr_i(fall_clr_i), .q_o(fall_q_o)
   );

   assign active_o = (rise_q_o & rise_en) | (fall_q_o & fall_en)
                   | (sel_i & hi_en) | (~sel_i & lo_en);
endmodule

// File: rtl/tic_ctrl.sv
module tic_ctrl
   import tic_pkg::*;
#(
   parameter int N_SRC       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_i,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [N_SRC-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [N_SRC-1:0]  rd_data,
   output logic              irq0_o,
   output logic              irq1_o,
   output logic              wake_o
);
   localparam logic [N_SRC-1:0] ONES = {N_SRC{1'b1}};

   if (N_SRC < 1) begin : g_bad_width
      $error("tic_ctrl needs at least one source");
   end

   logic [NREG-1:0][N_SRC-1:0] ctl_q;
   logic [N_SRC-1:0] swsrc_q, pin_s, sel, active;
   logic [N_SRC-1:0] rise_q, fall_q, rise_clr, fall_clr;
   logic [N_SRC-1:0] req0_w, req1_w;

   for (genvar k = 0; k < NREG; k++) begin : g_ctl
      localparam logic [N_SRC-1:0] RV =
         (k == R_ROUTE || k == R_SELECT) ? ONES : '0;
      logic [N_SRC-1:0] set_v, clr_v;
      assign set_v = (wr_en && wr_addr == ADDR_W'(a_set(k))) ? wr_data : '0;
      assign clr_v = (wr_en && wr_addr == ADDR_W'(a_clr(k))) ? wr_data : '0;
      tic_setclr_reg #(.W(N_SRC), .RST(RV)) u_reg (
         .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .q_o(ctl_q[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       swsrc_q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(A_SWSRC))    swsrc_q <= wr_data;
   end

   tic_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(pin_s)
   );

   assign sel = (pin_s & ctl_q[R_SELECT]) | (swsrc_q & ~ctl_q[R_SELECT]);

   assign rise_clr = (wr_en && wr_addr == ADDR_W'(A_RISE_CLR)) ? wr_data : '0;
   assign fall_clr = (wr_en && wr_addr == ADDR_W'(A_FALL_CLR)) ? wr_data : '0;

   tic_trigger #(.W(N_SRC)) u_trig (
      .clk(clk), .rst_n(rst_n), .sel_i(sel),
      .cfg0_i(ctl_q[R_CFG0]), .cfg1_i(ctl_q[R_CFG1]), .cfg2_i(ctl_q[R_CFG2]),
      .rise_clr_i(rise_clr), .fall_clr_i(fall_clr),
      .rise_q_o(rise_q), .fall_q_o(fall_q), .active_o(active)
   );

   assign req0_w = active & ctl_q[R_MASK] &  ctl_q[R_ROUTE];
   assign req1_w = active & ctl_q[R_MASK] & ~ctl_q[R_ROUTE];

   assign irq0_o = |req0_w;
   assign irq1_o = |req1_w;
   assign wake_o = |(active & ctl_q[R_WAKE]);

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NREG; k++) begin
         if (rd_addr == ADDR_W'(a_rd(k))) rd_data = ctl_q[k];
      end
      case (rd_addr)
         ADDR_W'(A_RISE_RD): rd_data = rise_q;
         ADDR_W'(A_FALL_RD): rd_data = fall_q;
         ADDR_W'(A_REQ0):    rd_data = req0_w;
         ADDR_W'(A_REQ1):    rd_data = req1_w;
         ADDR_W'(A_SWSRC):   rd_data = swsrc_q;
         default: ;
      endcase
   end
endmodule

// File: rtl/tic_ctrl_chk.sv
module tic_ctrl_chk
   import tic_pkg::*;
#(
   parameter int N = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [N-1:0]      wr_data,
   input logic [N-1:0]      mask_q,
   input logic [N-1:0]      rise_q,
   input logic [N-1:0]      fall_q,
   input logic [N-1:0]      req0_w,
   input logic [N-1:0]      req1_w
);
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (mask_q == '0 && rise_q == '0 && fall_q == '0));

   // R2
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(a_set(R_MASK)))
      |=> ((mask_q & $past(wr_data)) == $past(wr_data)));

   // R8
   pend_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((req0_w | req1_w) & ~mask_q) == '0);

   // R9
   route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req0_w & req1_w) == '0);

   // R5
   rise_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == ADDR_W'(A_RISE_CLR))
      |=> ((rise_q & $past(rise_q)) == $past(rise_q)));

   // R5
   fall_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == ADDR_W'(A_FALL_CLR))
      |=> ((fall_q & $past(fall_q)) == $past(fall_q)));
endmodule

bind tic_ctrl tic_ctrl_chk #(.N(N_SRC)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .mask_q(ctl_q[3]), .rise_q(rise_q), .fall_q(fall_q),
   .req0_w(req0_w), .req1_w(req1_w)
);

// File: tb/tic_ctrl_bench.sv
module tic_ctrl_bench;
   import tic_pkg::*;

   localparam int N = 32;
   localparam logic [N-1:0] ONES = '1;
   // {code[2:0], level_before, level_after, expected_pending}
   localparam logic [5:0] VEC [14] = '{
      6'b000_01_0, 6'b001_01_1, 6'b001_10_0, 6'b010_10_1, 6'b010_01_0,
      6'b011_01_1, 6'b011_10_1, 6'b101_01_1, 6'b101_10_0, 6'b110_10_1,
      6'b110_01_0, 6'b100_01_0, 6'b111_10_0, 6'b111_01_0
   };

   logic clk = 0, rst_n = 0;
   logic [N-1:0] src_i = '0;
   logic wr_en = 0;
   logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
   logic [N-1:0] wr_data = '0, rd_data;
   logic irq0_o, irq1_o, wake_o;
   int checks = 0, errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   tic_ctrl u_tic_ctrl (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq0_o(irq0_o), .irq1_o(irq1_o), .wake_o(wake_o)
   );

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [N-1:0] d);
      wr_en = 1; wr_addr = ADDR_W'(a); wr_data = d;
      @(posedge clk); @(negedge clk);
      wr_en = 0;
   endtask

   task automatic rd(input int a, output logic [N-1:0] d);
      rd_addr = ADDR_W'(a); #1; d = rd_data;
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic scrub();
      wr(a_clr(R_CFG0), ONES); wr(a_clr(R_CFG1), ONES); wr(a_clr(R_CFG2), ONES);
      wr(a_clr(R_MASK), ONES); wr(a_clr(R_WAKE), ONES);
      wr(a_set(R_ROUTE), ONES); wr(a_clr(R_SELECT), ONES);
      wr(A_SWSRC, '0); idle(2);
      wr(A_RISE_CLR, ONES); wr(A_FALL_CLR, ONES);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      rd(a_rd(R_CFG0), v);   check("R1 cfg0", v, '0);
      rd(a_rd(R_CFG2), v);   check("R1 cfg2", v, '0);
      rd(a_rd(R_MASK), v);   check("R1 mask", v, '0);
      rd(a_rd(R_WAKE), v);   check("R1 wake", v, '0);
      rd(a_rd(R_ROUTE), v);  check("R1 route", v, ONES);
      rd(a_rd(R_SELECT), v); check("R1 select", v, ONES);
      rd(A_RISE_RD, v);      check("R1 rise latch", v, '0);
      rd(A_FALL_RD, v);      check("R1 fall latch", v, '0);
      rd(A_SWSRC, v);        check("R1 sw source", v, '0);
      check("R1 outputs", N'({irq0_o, irq1_o, wake_o}), '0);

      // R2 set/clear aliases
      wr(a_set(R_MASK), 32'h0000_00F0); wr(a_set(R_MASK), 32'h0000_000F);
      rd(a_rd(R_MASK), v); check("R2 set merge", v, 32'h0000_00FF);
      wr(a_clr(R_MASK), 32'h0000_0003);
      rd(a_rd(R_MASK), v); check("R2 clear bits", v, 32'h0000_00FC);
      rd(63, v); check("R2 unmapped read", v, '0);

      // trigger table, source 0 from the software word
      foreach (VEC[i]) begin
         logic [2:0] code;
         string tag;
         code = VEC[i][5:3];
         case (code)
            3'b001: tag = "R3";
            3'b010: tag = "R4";
            3'b011: tag = "R5";
            3'b101, 3'b110: tag = "R6";
            default: tag = "R7";
         endcase
         scrub();
         wr(A_SWSRC, N'(VEC[i][2])); idle(2);
         if (code[0]) wr(a_set(R_CFG0), 1);
         if (code[1]) wr(a_set(R_CFG1), 1);
         if (code[2]) wr(a_set(R_CFG2), 1);
         wr(a_set(R_MASK), 1);
         wr(A_RISE_CLR, ONES); wr(A_FALL_CLR, ONES);
         wr(A_SWSRC, N'(VEC[i][1])); idle(2);
         rd(A_REQ0, v);
         check($sformatf("%s code %b vector %0d", tag, code, i), v, N'(VEC[i][0]));
         check($sformatf("R10 irq0 vector %0d", i), N'(irq0_o), N'(VEC[i][0]));
      end

      // R5 independent latch clears
      scrub();
      wr(a_set(R_CFG0), 2); wr(a_set(R_CFG1), 2); wr(a_set(R_MASK), 2);
      wr(A_SWSRC, 2); idle(2); wr(A_SWSRC, 0); idle(2);
      rd(A_RISE_RD, v); check("R5 rise caught", v, 2);
      rd(A_FALL_RD, v); check("R5 fall caught", v, 2);
      wr(A_RISE_CLR, 2);
      rd(A_RISE_RD, v); check("R5 rise cleared", v, 0);
      rd(A_FALL_RD, v); check("R5 fall kept", v, 2);
      rd(A_REQ0, v);    check("R5 still pending", v, 2);

      // R8 mask, R11 wake, R9 routing
      scrub();
      wr(a_set(R_CFG0), 4); wr(A_SWSRC, 4); idle(2);
      rd(A_REQ0, v);    check("R8 masked absent", v, 0);
      check("R8 irq0 low", N'(irq0_o), 0);
      rd(A_RISE_RD, v); check("R8 latch still set", v, 4);
      wr(a_set(R_WAKE), 4);
      check("R11 wake while masked", N'(wake_o), 1);
      wr(a_set(R_MASK), 4);
      rd(A_REQ0, v);    check("R8 unmask exposes", v, 4);
      wr(a_clr(R_ROUTE), 4);
      rd(A_REQ1, v);    check("R9 word1", v, 4);
      rd(A_REQ0, v);    check("R9 word0 empty", v, 0);
      check("R10 irq lines", N'({irq0_o, irq1_o}), 1);
      wr(a_clr(R_WAKE), 4);
      check("R11 wake off", N'(wake_o), 0);

      // R12 pin path through synchronizer
      scrub();
      wr(a_set(R_SELECT), 8); wr(a_set(R_CFG0), 8); wr(a_set(R_CFG2), 8);
      wr(a_set(R_MASK), 8); wr(A_SWSRC, 8); idle(1);
      rd(A_REQ0, v); check("R12 sw word ignored", v, 0);
      src_i = 8;
      @(posedge clk); @(negedge clk);
      rd(A_REQ0, v); check("R12 after one edge", v, 0);
      @(posedge clk); @(negedge clk);
      rd(A_REQ0, v); check("R12 after two edges", v, 8);
      src_i = 0;

      // R13 edge and clear on the same edge
      scrub();
      wr(a_set(R_CFG0), 16); wr(a_set(R_MASK), 16);
      wr(A_SWSRC, 16); wr(A_RISE_CLR, 16);
      rd(A_RISE_RD, v); check("R13 set wins", v, 16);
      wr(A_RISE_CLR, 16);
      rd(A_RISE_RD, v); check("R13 later clear", v, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule